// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox

This block lets one processor ring doorbells in another. It has two 32-bit register ports, one on the sending side and one on the receiving side. Each channel keeps one 32-bit pending word. The sender can only OR bits into that word. The receiver reads it, masks individual bits out of its interrupt, and clears bits one at a time or all together.

The sender first asks for access through a request bit. A ready bit follows the request one cycle later. Doorbell writes are accepted only while ready is high. The receiver gets one level-sensitive interrupt: the OR of the unmasked pending bits over all channels.

Both sides expose the same read-only channel count and an architecture identifier. Channel N occupies the 32-byte window that starts at byte offset N*0x20. The global registers sit in the last part of the 4 KiB frame.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, every pending word, every mask word, the access request bit and the ready bit are 0, and the interrupt output is low.
- R2: A sender write to window offset 0x0C ORs the write data into that channel's pending word, leaving bits already set unchanged; sender offset 0x00 reads the pending word.
- R3: A sender write to 0x0C is ignored while ready is 0.
- R4: Sender offset 0xF88 bit 0 is the readable and writable access request. Sender offset 0xF8C bit 0 is ready, which equals the request one clock later, on both the rising and the falling transition.
- R5: Receiver offset 0x00 reads the pending word. Receiver offset 0x04 reads the pending word ANDed with the inverse of the mask.
- R6: A receiver write to 0x08 clears each pending bit written as 1, so writing 0xFFFFFFFF empties the channel.
- R7: Receiver writes to 0x14 set mask bits and writes to 0x18 clear mask bits, one per written 1; receiver offset 0x10 reads the mask.
- R8: The interrupt output is high exactly when some channel has a pending bit whose mask bit is 0. It falls as soon as such bits are cleared or masked.
- R9: When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R10: Offset 0xF80 reads NUM_CH on both sides.
- R11: Offset 0xFCC reads the architecture identifier on both sides, with the major revision 1 in bits 7:4 and the minor revision (parameter, default 1) in bits 3:0.
- R12: Reads of write-only, reserved or unimplemented-channel offsets return 0. Writes to them, and to read-only registers, change nothing.
- R13: Read data is registered: it presents the addressed value from the clock edge that sampled the read enable, and reads 0 when no read was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_addr | input | 12 | Sender byte address |
| tx_wen | input | 1 | Sender write strobe |
| tx_wdata | input | 32 | Sender write data |
| tx_ren | input | 1 | Sender read strobe |
| tx_rdata | output | 32 | Sender read data, one cycle after the strobe |
| rx_addr | input | 12 | Receiver byte address |
| rx_wen | input | 1 | Receiver write strobe |
| rx_wdata | input | 32 | Receiver write data |
| rx_ren | input | 1 | Receiver read strobe |
| rx_rdata | output | 32 | Receiver read data, one cycle after the strobe |
| rx_irq | output | 1 | Level interrupt for unmasked pending doorbells |

## Verification
Doorbells are written as separate bit groups that accumulate in one channel, so an OR can be told apart from an overwrite. They also go to the first and last channels, which shows that the window is decoded by channel index. Partial clears, an all-ones clear and mask changes each move the interrupt by one step, and this separates the masked view from the raw pending word. A set and a clear that reach the same bit in the same cycle show which one has priority. Reads of ready just before and just after each request change pin down its one-cycle lag, and writes made while ready is low show the gating.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int WIN_SHIFT = 5;
  localparam int IDX_W     = ADDR_W - WIN_SHIFT;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // per-channel window offsets
  localparam logic [WIN_SHIFT-1:0] W_PEND   = 5'h00;
  localparam logic [WIN_SHIFT-1:0] W_VIEW   = 5'h04;
  localparam logic [WIN_SHIFT-1:0] W_CLR    = 5'h08;
  localparam logic [WIN_SHIFT-1:0] W_SET    = 5'h0C;
  localparam logic [WIN_SHIFT-1:0] W_MASK   = 5'h10;
  localparam logic [WIN_SHIFT-1:0] W_MSET   = 5'h14;
  localparam logic [WIN_SHIFT-1:0] W_MCLR   = 5'h18;

  // global offsets
  localparam addr_t G_COUNT = 12'hF80;
  localparam addr_t G_REQ   = 12'hF88;
  localparam addr_t G_RDY   = 12'hF8C;
  localparam addr_t G_ARCH  = 12'hFCC;

  function automatic logic [IDX_W-1:0] win_index(input addr_t a);
    return a[ADDR_W-1:WIN_SHIFT];
  endfunction

  function automatic logic [WIN_SHIFT-1:0] win_reg(input addr_t a);
    return a[WIN_SHIFT-1:0];
  endfunction

  function automatic logic in_window(input addr_t a, input int unsigned nch);
    return int'(win_index(a)) < int'(nch);
  endfunction

  function automatic word_t pend_next(input word_t cur, input word_t setb, input word_t clrb);
    return (cur & ~clrb) | setb;
  endfunction

  function automatic word_t arch_word(input logic [3:0] major, input logic [3:0] minor);
    return {24'h0, major, minor};
  endfunction
endpackage

// File: rtl/dbmb_access_ctl.sv
module dbmb_access_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_we,
  input  logic req_val,
  output logic acc_req,
  output logic acc_rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_req <= 1'b0;
      acc_rdy <= 1'b0;
    end else begin
      if (req_we) acc_req <= req_val;
      acc_rdy <= acc_req;
    end
  end
endmodule

// File: rtl/dbmb_channel.sv
module dbmb_channel
  import dbmb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_bits,
  input  word_t clr_bits,
  input  word_t mset_bits,
  input  word_t mclr_bits,
  output word_t pend,
  output word_t mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= pend_next(pend, set_bits, clr_bits);
      mask <= (mask & ~mclr_bits) | mset_bits;
    end
  end
endmodule

// File: rtl/dbmb_tx_port.sv
module dbmb_tx_port
  import dbmb_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter logic [3:0]  ARCH_MINOR = 4'd1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  addr_t                   addr,
  input  logic                    wen,
  input  word_t                   wdata,
  input  logic                    ren,
  output word_t                   rdata,
  input  logic                    acc_req,
  input  logic                    acc_rdy,
  input  word_t [NUM_CH-1:0]      pend,
  output word_t [NUM_CH-1:0]      set_bits,
  output logic                    req_we,
  output logic                    req_val
);
  logic                 hit_win;
  logic [IDX_W-1:0]     idx;
  logic [WIN_SHIFT-1:0] wreg;
  word_t                rd_val;

  assign hit_win = in_window(addr, NUM_CH);
  assign idx     = win_index(addr);
  assign wreg    = win_reg(addr);
  assign req_we  = wen && (addr == G_REQ);
  assign req_val = wdata[0];

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_set
    assign set_bits[i] = (wen && acc_rdy && hit_win && idx == IDX_W'(i) && wreg == W_SET)
                         ? wdata : '0;
  end

  always_comb begin
    rd_val = '0;
    if (hit_win) begin
      for (int i = 0; i < int'(NUM_CH); i++)
        if (idx == IDX_W'(i) && wreg == W_PEND) rd_val = pend[i];
    end else begin
      case (addr)
        G_COUNT: rd_val = DATA_W'(NUM_CH);
        G_REQ:   rd_val = {31'h0, acc_req};
        G_RDY:   rd_val = {31'h0, acc_rdy};
        G_ARCH:  rd_val = arch_word(4'd1, ARCH_MINOR);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= ren ? rd_val : '0;
  end
endmodule

// File: rtl/dbmb_rx_port.sv
module dbmb_rx_port
  import dbmb_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter logic [3:0]  ARCH_MINOR = 4'd1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  addr_t              addr,
  input  logic               wen,
  input  word_t              wdata,
  input  logic               ren,
  output word_t              rdata,
  input  word_t [NUM_CH-1:0] pend,
  input  word_t [NUM_CH-1:0] mask,
  output word_t [NUM_CH-1:0] clr_bits,
  output word_t [NUM_CH-1:0] mset_bits,
  output word_t [NUM_CH-1:0] mclr_bits
);
  logic                 hit_win;
  logic [IDX_W-1:0]     idx;
  logic [WIN_SHIFT-1:0] wreg;
  word_t                rd_val;

  assign hit_win = in_window(addr, NUM_CH);
  assign idx     = win_index(addr);
  assign wreg    = win_reg(addr);

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_wr
    logic sel;
    assign sel          = wen && hit_win && idx == IDX_W'(i);
    assign clr_bits[i]  = (sel && wreg == W_CLR)  ? wdata : '0;
    assign mset_bits[i] = (sel && wreg == W_MSET) ? wdata : '0;
    assign mclr_bits[i] = (sel && wreg == W_MCLR) ? wdata : '0;
  end

  always_comb begin
    rd_val = '0;
    if (hit_win) begin
      for (int i = 0; i < int'(NUM_CH); i++) begin
        if (idx == IDX_W'(i)) begin
          case (wreg)
            W_PEND:  rd_val = pend[i];
            W_VIEW:  rd_val = pend[i] & ~mask[i];
            W_MASK:  rd_val = mask[i];
            default: rd_val = '0;
          endcase
        end
      end
    end else begin
      case (addr)
        G_COUNT: rd_val = DATA_W'(NUM_CH);
        G_ARCH:  rd_val = arch_word(4'd1, ARCH_MINOR);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= ren ? rd_val : '0;
  end
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import dbmb_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter logic [3:0]  ARCH_MINOR = 4'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] tx_addr,
  input  logic        tx_wen,
  input  logic [31:0] tx_wdata,
  input  logic        tx_ren,
  output logic [31:0] tx_rdata,
  input  logic [11:0] rx_addr,
  input  logic        rx_wen,
  input  logic [31:0] rx_wdata,
  input  logic        rx_ren,
  output logic [31:0] rx_rdata,
  output logic        rx_irq
);
  // named internal events, observed by the bound checker
  word_t [NUM_CH-1:0] ch_pend;
  word_t [NUM_CH-1:0] ch_mask;
  word_t [NUM_CH-1:0] ch_set;
  word_t [NUM_CH-1:0] ch_clr;
  word_t [NUM_CH-1:0] ch_mset;
  word_t [NUM_CH-1:0] ch_mclr;
  logic  [NUM_CH-1:0] ch_live;
  logic               acc_req;
  logic               acc_rdy;
  logic               req_we;
  logic               req_val;

  dbmb_access_ctl u_acc (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_val(req_val),
    .acc_req(acc_req), .acc_rdy(acc_rdy)
  );

  dbmb_tx_port #(.NUM_CH(NUM_CH), .ARCH_MINOR(ARCH_MINOR)) u_tx (
    .clk(clk), .rst_n(rst_n), .addr(tx_addr), .wen(tx_wen), .wdata(tx_wdata),
    .ren(tx_ren), .rdata(tx_rdata), .acc_req(acc_req), .acc_rdy(acc_rdy),
    .pend(ch_pend), .set_bits(ch_set), .req_we(req_we), .req_val(req_val)
  );

  dbmb_rx_port #(.NUM_CH(NUM_CH), .ARCH_MINOR(ARCH_MINOR)) u_rx (
    .clk(clk), .rst_n(rst_n), .addr(rx_addr), .wen(rx_wen), .wdata(rx_wdata),
    .ren(rx_ren), .rdata(rx_rdata), .pend(ch_pend), .mask(ch_mask),
    .clr_bits(ch_clr), .mset_bits(ch_mset), .mclr_bits(ch_mclr)
  );

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
    dbmb_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .set_bits(ch_set[i]), .clr_bits(ch_clr[i]),
      .mset_bits(ch_mset[i]), .mclr_bits(ch_mclr[i]),
      .pend(ch_pend[i]), .mask(ch_mask[i])
    );
    assign ch_live[i] = |(ch_pend[i] & ~ch_mask[i]);
  end

  assign rx_irq = |ch_live;
endmodule

// File: rtl/dbmb_chk.sv
module dbmb_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_req,
  input logic                    acc_rdy,
  input logic                    rx_irq,
  input logic [NUM_CH-1:0][31:0] ch_pend,
  input logic [NUM_CH-1:0][31:0] ch_mask,
  input logic [NUM_CH-1:0][31:0] ch_set,
  input logic [NUM_CH-1:0][31:0] ch_clr,
  input logic [NUM_CH-1:0][31:0] ch_mset,
  input logic [NUM_CH-1:0][31:0] ch_mclr
);
  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_rdy) |-> $past(acc_req));
  // R4
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_rdy) |-> !$past(acc_req));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pend == '0) |-> !rx_irq);

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_c
    // R3
    no_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rdy |=> ((ch_pend[i] & ~$past(ch_pend[i])) == '0));
    // R9
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_set[i] != '0) |=> ((ch_pend[i] & $past(ch_set[i])) == $past(ch_set[i])));
    // R6
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_clr[i] != '0 && ch_set[i] == '0) |=> ((ch_pend[i] & $past(ch_clr[i])) == '0));
    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mset[i] == '0 && ch_mclr[i] == '0) |=> $stable(ch_mask[i]));
  end
endmodule

bind doorbell_mbox dbmb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_rdy(acc_rdy), .rx_irq(rx_irq),
  .ch_pend(ch_pend), .ch_mask(ch_mask), .ch_set(ch_set), .ch_clr(ch_clr),
  .ch_mset(ch_mset), .ch_mclr(ch_mclr)
);

// File: tb/doorbell_mbox_tb_top.sv
`timescale 1ns/1ps
module doorbell_mbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] tx_addr = '0;
  logic        tx_wen = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_ren = 1'b0;
  logic [31:0] tx_rdata;
  logic [11:0] rx_addr = '0;
  logic        rx_wen = 1'b0;
  logic [31:0] rx_wdata = '0;
  logic        rx_ren = 1'b0;
  logic [31:0] rx_rdata;
  logic        rx_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] tx_exp_q[$];
  string       tx_tag_q[$];
  logic [31:0] rx_exp_q[$];
  string       rx_tag_q[$];
  logic        tx_pend = 1'b0;
  logic        rx_pend = 1'b0;

  always #4 clk = ~clk;

  doorbell_mbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_addr(tx_addr), .tx_wen(tx_wen), .tx_wdata(tx_wdata), .tx_ren(tx_ren), .tx_rdata(tx_rdata),
    .rx_addr(rx_addr), .rx_wen(rx_wen), .rx_wdata(rx_wdata), .rx_ren(rx_ren), .rx_rdata(rx_rdata),
    .rx_irq(rx_irq)
  );

  function automatic void check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: reads sampled at a rising edge are compared at the following falling edge
  always @(posedge clk) begin
    tx_pend <= tx_ren;
    rx_pend <= rx_ren;
  end

  always @(negedge clk) begin
    if (tx_pend && tx_exp_q.size() > 0) check(tx_rdata, tx_exp_q.pop_front(), tx_tag_q.pop_front());
    if (rx_pend && rx_exp_q.size() > 0) check(rx_rdata, rx_exp_q.pop_front(), rx_tag_q.pop_front());
  end

  // drivers: each starts and ends on a falling edge
  task automatic tx_wr(input logic [11:0] a, input logic [31:0] d);
    tx_addr = a; tx_wdata = d; tx_wen = 1'b1;
    @(negedge clk); tx_wen = 1'b0;
  endtask

  task automatic rx_wr(input logic [11:0] a, input logic [31:0] d);
    rx_addr = a; rx_wdata = d; rx_wen = 1'b1;
    @(negedge clk); rx_wen = 1'b0;
  endtask

  task automatic tx_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    tx_addr = a; tx_ren = 1'b1;
    tx_exp_q.push_back(e); tx_tag_q.push_back(tag);
    @(negedge clk); tx_ren = 1'b0;
  endtask

  task automatic rx_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rx_addr = a; rx_ren = 1'b1;
    rx_exp_q.push_back(e); rx_tag_q.push_back(tag);
    @(negedge clk); rx_ren = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({31'h0, rx_irq}, 32'h0, "R1 irq after reset");
    tx_rd(12'h000, 32'h0, "R1 pending ch0");
    tx_rd(12'hF88, 32'h0, "R1 request");
    tx_rd(12'hF8C, 32'h0, "R1 ready");
    rx_rd(12'h010, 32'h0, "R1 mask ch0");
    // R13 idle read data
    check(tx_rdata, 32'h0, "R13 idle tx read data");

    // R10 / R11 global registers on both sides
    tx_rd(12'hF80, 32'd4, "R10 tx count");
    rx_rd(12'hF80, 32'd4, "R10 rx count");
    tx_rd(12'hFCC, 32'h11, "R11 tx arch");
    rx_rd(12'hFCC, 32'h11, "R11 rx arch");

    // R3 set ignored while not ready
    tx_wr(12'h02C, 32'hFF);
    rx_rd(12'h020, 32'h0, "R3 set before ready");

    // R4 handshake, one-cycle lag
    tx_wr(12'hF88, 32'h1);
    tx_rd(12'hF8C, 32'h0, "R4 ready lags request");
    tx_rd(12'hF8C, 32'h1, "R4 ready risen");
    tx_rd(12'hF88, 32'h1, "R4 request readback");

    // R2 accumulate
    tx_wr(12'h00C, 32'h05);
    tx_wr(12'h00C, 32'h30);
    tx_rd(12'h000, 32'h35, "R2 OR accumulate");
    rx_rd(12'h000, 32'h35, "R5 rx pending");
    tx_wr(12'h06C, 32'h8000_0000);
    rx_rd(12'h060, 32'h8000_0000, "R2 last channel");
    check({31'h0, rx_irq}, 32'h1, "R8 irq with pending");

    // R7 mask, R5 masked view
    rx_wr(12'h014, 32'h35);
    rx_rd(12'h010, 32'h35, "R7 mask set");
    rx_rd(12'h004, 32'h0, "R5 masked view empty");
    check({31'h0, rx_irq}, 32'h1, "R8 irq from other channel");

    // R6 clear all
    rx_wr(12'h068, 32'hFFFF_FFFF);
    rx_rd(12'h060, 32'h0, "R6 clear all");
    check({31'h0, rx_irq}, 32'h0, "R8 irq fully masked");

    rx_wr(12'h018, 32'h01);
    check({31'h0, rx_irq}, 32'h1, "R8 irq after unmask");
    rx_rd(12'h004, 32'h01, "R5 masked view one bit");
    rx_rd(12'h010, 32'h34, "R7 mask clear");

    // R6 partial clear
    rx_wr(12'h008, 32'h04);
    rx_rd(12'h000, 32'h31, "R6 partial clear");

    // R9 same-cycle set and clear
    tx_wr(12'h04C, 32'h01);
    tx_addr = 12'h04C; tx_wdata = 32'h40; tx_wen = 1'b1;
    rx_addr = 12'h048; rx_wdata = 32'h41; rx_wen = 1'b1;
    @(negedge clk); tx_wen = 1'b0; rx_wen = 1'b0;
    rx_rd(12'h040, 32'h40, "R9 set wins");

    // R12 reserved, write-only, unimplemented
    tx_rd(12'h00C, 32'h0, "R12 write-only set reads 0");
    tx_rd(12'h004, 32'h0, "R12 reserved tx");
    rx_rd(12'h008, 32'h0, "R12 write-only clear reads 0");
    rx_rd(12'h014, 32'h0, "R12 write-only mask set reads 0");
    tx_wr(12'h0AC, 32'hFFFF_FFFF);
    rx_wr(12'h0A8, 32'hFFFF_FFFF);
    rx_rd(12'h0A0, 32'h0, "R12 unimplemented channel");
    rx_rd(12'h000, 32'h31, "R12 ch0 untouched");
    rx_rd(12'h040, 32'h40, "R12 ch2 untouched");
    tx_wr(12'hFCC, 32'h0);
    tx_rd(12'hFCC, 32'h11, "R12 arch write ignored");
    rx_wr(12'hF80, 32'h0);
    rx_rd(12'hF80, 32'd4, "R12 count write ignored");

    // R4 release, R3 set ignored afterwards
    tx_wr(12'hF88, 32'h0);
    tx_rd(12'hF8C, 32'h1, "R4 ready lags release");
    tx_rd(12'hF8C, 32'h0, "R4 ready fallen");
    tx_wr(12'h02C, 32'hF0);
    rx_rd(12'h020, 32'h0, "R3 set after release");

    repeat (3) @(negedge clk);
    check(rx_rdata, 32'h0, "R13 idle rx read data");
    finish_run();
  end
endmodule